// File: doc/BRIEF.md
# Call and interrupt vector generator

This block forms the target program counter for every control transfer that does not come from an ordinary branch. The transfers it handles are reset, interrupts, the compact one-byte table call, the two-byte page call and the software break.

For every kind except the page call, the block first computes a vector address. It then reads two bytes from that address through a simple read port with combinational read data: the low byte comes first, then the high byte. Only after both bytes are captured does it load the assembled word into its program counter register. A page call needs no memory access, because its target is formed directly inside the top page. The program counter register can also be stepped by one while the block is idle, and it wraps from FFFFh to 0000h.

A request is taken only while the block is idle. Any request that arrives while a transfer is running is dropped. Instruction decode and the choice between competing interrupts happen upstream.

Top module: `call_vector_gen`

## Requirements
- R1: After reset release, busy_o, rd_en_o, pc_load_o and brk_o are 0 and pc_o is 0000h.
- R2: A request of kind 0 (reset) reads address FFFEh, then FFFFh, and loads pc_o with {byte at FFFFh, byte at FFFEh}.
- R3: A request of kind 1 (interrupt) with source s uses vector FFFAh - 2s: source 1 gives FFF8h, source 2 gives FFF6h, source 9 gives FFE8h.
- R4: A request of kind 2 (table call) with index n in 0..15 uses vector FFDEh - 2n, so index 15 lands on FFC0h.
- R5: A request of kind 3 (page call) with operand p issues no read. In the cycle after acceptance it loads pc_o with FF00h + p and raises pc_load_o.
- R6: A request of kind 4 (break) uses vector FFDEh, the same vector as table index 0. It raises brk_o together with pc_load_o. brk_o is 0 for every other kind.
- R7: Take the edge at which a vector request is accepted. In the next cycle, rd_en_o is 1 with rd_addr_o at the vector. In the cycle after that, rd_addr_o is vector + 1. In the third cycle, rd_en_o is 0, pc_o holds the new value and pc_load_o is 1 for that single cycle. pc_o does not change before then.
- R8: busy_o is 1 from the cycle after acceptance through the pc_load_o cycle. Requests made while busy_o is 1 have no effect on the reads or on pc_o.
- R9: While the block is idle and no request is accepted, pc_inc_i adds 1 to pc_o at the next edge, and FFFFh steps to 0000h. Otherwise pc_o holds its value.
- R10: Request kinds 5, 6 and 7 are ignored: busy_o stays 0, no read is issued and pc_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request strobe |
| req_kind_i | input | 3 | 0 reset, 1 interrupt, 2 table call, 3 page call, 4 break |
| tcall_idx_i | input | 4 | Table call index |
| pcall_op_i | input | 8 | Page call operand |
| irq_src_i | input | 4 | Interrupt source number |
| pc_inc_i | input | 1 | Step pc_o by one when idle |
| rd_data_i | input | 8 | Byte read at rd_addr_o, same cycle |
| rd_en_o | output | 1 | Vector read active |
| rd_addr_o | output | 16 | Vector byte address |
| pc_o | output | 16 | Program counter |
| pc_load_o | output | 1 | One-cycle strobe: pc_o holds a new target |
| brk_o | output | 1 | Break marker, coincident with pc_load_o |
| busy_o | output | 1 | Transfer in progress |

## Verification
A corrupted vector register or index arithmetic shows up on rd_addr_o in the first read cycle, one cycle after acceptance. A lost or swapped captured byte appears on pc_o in the load cycle, three cycles after acceptance. A stuck sequencer state shows up within one cycle as busy_o, rd_en_o or pc_load_o out of step with the reference model, which is compared every clock. A mis-kept break flag is seen on brk_o in the load cycle.

// File: rtl/cvg_pkg.sv
package cvg_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  localparam logic [2:0] K_RESET = 3'd0;
  localparam logic [2:0] K_IRQ   = 3'd1;
  localparam logic [2:0] K_TCALL = 3'd2;
  localparam logic [2:0] K_PCALL = 3'd3;
  localparam logic [2:0] K_BRK   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_LOAD = 2'd3
  } cvg_state_e;
endpackage

// File: rtl/cvg_addr_map.sv
module cvg_addr_map
  import cvg_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned SRC_W     = 4,
  parameter logic [15:0] RESET_VEC = 16'hFFFE,
  parameter logic [15:0] IRQ_TOP   = 16'hFFFA,
  parameter logic [15:0] TBL_TOP   = 16'hFFDE,
  parameter logic [15:0] PAGE_BASE = 16'hFF00
) (
  input  logic [2:0]       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DW-1:0]    op_i,
  output logic [AW-1:0]    vec_o,
  output logic [AW-1:0]    page_tgt_o
);
  localparam int unsigned ENTRY_SH = 1; // 2 bytes per vector

  logic [AW-1:0] idx_off, src_off;

  assign idx_off    = AW'(idx_i) << ENTRY_SH;
  assign src_off    = AW'(src_i) << ENTRY_SH;
  assign page_tgt_o = PAGE_BASE | AW'(op_i);

  always_comb begin
    unique case (kind_i)
      K_IRQ:   vec_o = IRQ_TOP - src_off;
      K_TCALL: vec_o = TBL_TOP - idx_off;
      K_BRK:   vec_o = TBL_TOP;
      default: vec_o = RESET_VEC;
    endcase
  end
endmodule

// File: rtl/cvg_seq.sv
module cvg_seq
  import cvg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] vec_i,
  input  logic [AW-1:0] page_tgt_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          pc_inc_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          pc_load_o,
  output logic          brk_o,
  output logic          pc_wr_o,
  output logic [AW-1:0] pc_wr_val_o,
  output logic          inc_en_o
);
  cvg_state_e    state_q, state_d;
  logic [AW-1:0] vec_q;
  logic [DW-1:0] lo_q;
  logic          brk_q;
  logic          kind_ok, accept, is_page;

  assign kind_ok = (kind_i <= K_BRK);
  assign accept  = (state_q == ST_IDLE) && req_valid_i && kind_ok;
  assign is_page = (kind_i == K_PCALL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = is_page ? ST_LOAD : ST_LO;
      ST_LO:   state_d = ST_HI;
      ST_HI:   state_d = ST_LOAD;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      lo_q    <= '0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vec_q <= vec_i;
        brk_q <= (kind_i == K_BRK);
      end
      if (state_q == ST_LO) lo_q <= rd_data_i;
    end
  end

  assign rd_en_o     = (state_q == ST_LO) || (state_q == ST_HI);
  assign rd_addr_o   = (state_q == ST_HI) ? vec_q + AW'(1) : vec_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign pc_load_o   = (state_q == ST_LOAD);
  assign brk_o       = pc_load_o && brk_q;
  assign pc_wr_o     = (accept && is_page) || (state_q == ST_HI);
  assign pc_wr_val_o = (state_q == ST_HI) ? {rd_data_i, lo_q} : page_tgt_i;
  assign inc_en_o    = (state_q == ST_IDLE) && !accept && pc_inc_i;

  // R7
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LO) |=> (state_q == ST_HI && rd_addr_o == $past(rd_addr_o) + 16'd1));

  // R7
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  // R8
  idle_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);

  // R10
  bad_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && kind_i > K_BRK) |=> !busy_o);
endmodule

// File: rtl/cvg_pc_reg.sv
module cvg_pc_reg
  import cvg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_o <= '0;
    else if (wr_i)  pc_o <= wr_val_i;
    else if (inc_i) pc_o <= pc_o + AW'(1); // natural wrap
  end

  // R9
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> (pc_o == $past(pc_o)));

  // R9
  pc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && pc_o == 16'hFFFF) |=> (pc_o == 16'h0000));
endmodule

// File: rtl/call_vector_gen.sv
module call_vector_gen
  import cvg_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SRC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_kind_i,
  input  logic [IDX_W-1:0] tcall_idx_i,
  input  logic [7:0]       pcall_op_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             pc_inc_i,
  input  logic [7:0]       rd_data_i,
  output logic             rd_en_o,
  output logic [15:0]      rd_addr_o,
  output logic [15:0]      pc_o,
  output logic             pc_load_o,
  output logic             brk_o,
  output logic             busy_o
);
  logic [AW-1:0] vec, page_tgt, pc_wr_val;
  logic          pc_wr, inc_en;

  cvg_addr_map #(.IDX_W(IDX_W), .SRC_W(SRC_W)) u_map (
    .kind_i     (req_kind_i),
    .idx_i      (tcall_idx_i),
    .src_i      (irq_src_i),
    .op_i       (pcall_op_i),
    .vec_o      (vec),
    .page_tgt_o (page_tgt)
  );

  cvg_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .kind_i      (req_kind_i),
    .vec_i       (vec),
    .page_tgt_i  (page_tgt),
    .rd_data_i   (rd_data_i),
    .pc_inc_i    (pc_inc_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .busy_o      (busy_o),
    .pc_load_o   (pc_load_o),
    .brk_o       (brk_o),
    .pc_wr_o     (pc_wr),
    .pc_wr_val_o (pc_wr_val),
    .inc_en_o    (inc_en)
  );

  cvg_pc_reg u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (pc_wr),
    .wr_val_i (pc_wr_val),
    .inc_i    (inc_en),
    .pc_o     (pc_o)
  );
endmodule

// File: tb/call_vector_gen_bench.sv
`timescale 1ns/1ps
module call_vector_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_kind_i = 3'd0;
  logic [3:0]  tcall_idx_i = 4'd0;
  logic [7:0]  pcall_op_i = 8'd0;
  logic [3:0]  irq_src_i = 4'd0;
  logic        pc_inc_i = 1'b0;
  logic [7:0]  rd_data_i;
  logic        rd_en_o, pc_load_o, brk_o, busy_o;
  logic [15:0] rd_addr_o, pc_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  call_vector_gen u_call_vector_gen (
    .clk_i, .rst_ni, .req_valid_i, .req_kind_i, .tcall_idx_i, .pcall_op_i,
    .irq_src_i, .pc_inc_i, .rd_data_i, .rd_en_o, .rd_addr_o, .pc_o,
    .pc_load_o, .brk_o, .busy_o
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C ^ {a[3:0], a[7:4]};
  endfunction

  assign rd_data_i = mem(rd_addr_o);

  function automatic logic [15:0] vec_word(input logic [15:0] v);
    return {mem(v + 16'd1), mem(v)};
  endfunction

  // reference model
  int          m_ph;
  logic [15:0] m_vec, m_pc;
  logic [7:0]  m_lo;
  bit          m_brk;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_vec = 16'h0; m_pc = 16'h0; m_lo = 8'h0; m_brk = 0;
    end else begin
      case (m_ph)
        0: begin
          if (req_valid_i && req_kind_i <= 3'd4) begin
            m_brk = (req_kind_i == 3'd4);
            case (req_kind_i)
              3'd0: m_vec = 16'hFFFE;
              3'd1: m_vec = 16'hFFFA - 16'(2 * int'(irq_src_i));
              3'd2: m_vec = 16'hFFDE - 16'(2 * int'(tcall_idx_i));
              default: m_vec = 16'hFFDE;
            endcase
            if (req_kind_i == 3'd3) begin
              m_pc = 16'hFF00 + 16'(pcall_op_i);
              m_ph = 3;
            end else m_ph = 1;
          end else if (pc_inc_i) m_pc = m_pc + 16'd1;
        end
        1: begin m_lo = mem(m_vec); m_ph = 2; end
        2: begin m_pc = {mem(m_vec + 16'd1), m_lo}; m_ph = 3; end
        default: begin m_ph = 0; m_brk = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(busy_o == (m_ph != 0), "R8 busy", 16'(busy_o), 16'(m_ph != 0));
      check(rd_en_o == (m_ph == 1 || m_ph == 2), "R7 rd_en", 16'(rd_en_o), 16'(m_ph == 1 || m_ph == 2));
      if (m_ph == 1) check(rd_addr_o == m_vec, "R7 lo addr", rd_addr_o, m_vec);
      if (m_ph == 2) check(rd_addr_o == m_vec + 16'd1, "R7 hi addr", rd_addr_o, m_vec + 16'd1);
      check(pc_load_o == (m_ph == 3), "R7 pc_load", 16'(pc_load_o), 16'(m_ph == 3));
      check(brk_o == (m_ph == 3 && m_brk), "R6 brk", 16'(brk_o), 16'(m_ph == 3 && m_brk));
      check(pc_o == m_pc, "R7 pc", pc_o, m_pc);
    end
  end

  task automatic req(input logic [2:0] k, input logic [3:0] idx, input logic [3:0] src, input logic [7:0] op);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = k; tcall_idx_i = idx; irq_src_i = src; pcall_op_i = op;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // returns at the negedge of the load cycle
  task automatic wait_load();
    while (!pc_load_o) @(negedge clk_i);
  endtask

  task automatic vec_case(input logic [2:0] k, input logic [3:0] idx, input logic [3:0] src,
                          input logic [15:0] v, input string tag);
    req(k, idx, src, 8'h00);
    check(rd_en_o && rd_addr_o == v, tag, rd_addr_o, v);
    wait_load();
    check(pc_o == vec_word(v), tag, pc_o, vec_word(v));
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(!busy_o && !rd_en_o && !pc_load_o && !brk_o, "R1 flags", {12'h0, busy_o, rd_en_o, pc_load_o, brk_o}, 16'h0);
    check(pc_o == 16'h0000, "R1 pc", pc_o, 16'h0000);

    vec_case(3'd0, 4'd0, 4'd0, 16'hFFFE, "R2 reset vector");
    vec_case(3'd1, 4'd0, 4'd1, 16'hFFF8, "R3 irq src1");
    vec_case(3'd1, 4'd0, 4'd2, 16'hFFF6, "R3 irq src2");
    vec_case(3'd1, 4'd0, 4'd9, 16'hFFE8, "R3 irq src9");
    vec_case(3'd2, 4'd15, 4'd0, 16'hFFC0, "R4 tcall 15");
    vec_case(3'd2, 4'd0, 4'd0, 16'hFFDE, "R4 tcall 0");
    vec_case(3'd2, 4'd7, 4'd0, 16'hFFD0, "R4 tcall 7");

    // R6: break shares the table-0 vector
    req(3'd4, 4'd0, 4'd0, 8'h00);
    wait_load();
    check(brk_o == 1'b1, "R6 brk set", 16'(brk_o), 16'h1);
    check(pc_o == vec_word(16'hFFDE), "R6 brk pc", pc_o, vec_word(16'hFFDE));
    @(negedge clk_i);

    // R5: page call, no reads
    req(3'd3, 4'd0, 4'd0, 8'h12);
    check(pc_load_o && !rd_en_o && pc_o == 16'hFF12, "R5 page 12", pc_o, 16'hFF12);
    @(negedge clk_i);
    req(3'd3, 4'd0, 4'd0, 8'hFF);
    check(pc_o == 16'hFFFF, "R5 page FF", pc_o, 16'hFFFF);

    // R9: increment wraps
    @(negedge clk_i);
    pc_inc_i = 1'b1;
    @(negedge clk_i);
    pc_inc_i = 1'b0;
    check(pc_o == 16'h0000, "R9 wrap", pc_o, 16'h0000);
    pc_inc_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pc_inc_i = 1'b0;
    check(pc_o == 16'h0003, "R9 step", pc_o, 16'h0003);

    // R10: bad kinds ignored
    for (int k = 5; k < 8; k++) begin
      req(3'(k), 4'd3, 4'd3, 8'h55);
      check(!busy_o && !rd_en_o && pc_o == 16'h0003, "R10 ignored", pc_o, 16'h0003);
    end

    // R8: request and increment while busy are ignored
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = 3'd2; tcall_idx_i = 4'd3;
    @(negedge clk_i);
    req_kind_i = 3'd3; pcall_op_i = 8'h44; pc_inc_i = 1'b1;
    @(negedge clk_i);
    req_kind_i = 3'd1; irq_src_i = 4'd5;
    @(negedge clk_i);
    req_valid_i = 1'b0; pc_inc_i = 1'b0;
    check(pc_o == vec_word(16'hFFD8), "R8 busy ignore", pc_o, vec_word(16'hFFD8));
    @(negedge clk_i);
    check(!busy_o, "R8 idle after", 16'(busy_o), 16'h0);

    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule